// File: doc/BRIEF.md
# Word-Mark Delimited Instruction Fetch Sequencer

This block fetches one variable-length instruction from a character-serial storage port, taking one character per accepted storage cycle. Each character is 8 bits. Bit 7 is the word mark, bit 6 is the check bit, bits 5 and 4 are the B and A zone bits, and bits 3:0 are the 8-4-2-1 numeric bits. Nothing in the op code gives the instruction length. The sequencer keeps reading until it meets a character that carries a word mark, which is the first character of the next instruction. While it reads, it fills the operation register, the A-address and B-address registers, the A and B character registers and a d-modifier register, each in a fixed pattern set by the character's position.

A fetch starts with a `start` pulse that carries the instruction address. Characters arrive on a valid/ready stream. The block drives `fetch_addr` and raises `chr_ready` only while it is fetching. The storage side presents the character found at `fetch_addr` with `chr_valid`. A character is taken on a clock edge where both are high. Holding `chr_valid` low stalls the fetch, and `fetch_addr` does not move.

A legal instruction is offered on `ins_valid`. It stays up with all outputs frozen until `ins_ready`, and then the block returns to idle. An instruction of illegal length raises `ins_bad` instead. It holds until the next `start`, which is accepted in that state. In both cases `fetch_addr` is left pointing at the terminating character, so the next `start` can continue the program from there. A one-character instruction leaves both address registers untouched, so an instruction can use the addresses left by the one before it (chaining).

Top module: `ifs_fetch`

## Requirements
- R1: After reset the block is idle with `chr_ready`, `ins_valid` and `ins_bad` low. `op_code`, `d_char` and every digit of `a_addr` and `b_addr` hold the blank code 7'h40 (check bit only). `a_char` and `b_char` hold 8'h40, and `ins_len` is 0.
- R2: A `start` in idle loads `fetch_addr` with `start_addr` and raises `chr_ready`. Each accepted character other than the terminating one advances `fetch_addr` by one. A cycle with `chr_valid` low leaves `fetch_addr` unchanged.
- R3: The first accepted character is the op code. Its bits 6:0, without the word mark, go to `op_code`, and all 8 bits go to `b_char`.
- R4: Characters 2, 3 and 4 are written to the hundreds [20:14], tens [13:7] and units [6:0] digits of both `a_addr` and `b_addr`. When character 2 arrives, the tens and units of `a_addr` become blank. The tens and units of `b_addr` also become blank, unless bits 5:0 of the op code are 6'h24, 6'h23 or 6'h38. For those three op codes `b_addr` keeps its tens and units.
- R5: Character 5 blanks `b_addr` and writes its hundreds digit. Characters 6 and 7 write its tens and units. Characters 5 to 8 leave `a_addr` unchanged.
- R6: The terminating character, the first one after the op code with bit 7 set, is written only to `b_char`. `fetch_addr` stays on it. One cycle after it is accepted, `ins_valid` or `ins_bad` rises, and `ins_len` gives the count of characters before it.
- R7: A one-character instruction leaves `a_addr` and `b_addr` exactly as the previous instruction left them.
- R8: A length of 3 or 6 raises `ins_bad` and never `ins_valid`. `ins_bad` stays high until the next `start`, and that `start` begins a new fetch.
- R9: Characters 9 and later change no register, but each one still advances `fetch_addr`. `ins_len` counts them, up to a limit of 15, and the instruction is legal.
- R10: For lengths 2, 5 and 8, `d_present` is high and `d_char` holds bits 6:0 of the last character. For other lengths `d_present` is low.
- R11: Every character in positions 2 to 8 is copied, all 8 bits, into both `a_char` and `b_char`.
- R12: `ins_valid` and all result outputs hold steady while `ins_ready` is low. The cycle after `ins_ready` is seen, the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a fetch at `start_addr` |
| start_addr | input | ADDR_W | Address of the op code |
| chr_valid | input | 1 | Storage character is present |
| chr_ready | output | 1 | Sequencer takes a character this cycle |
| chr_data | input | 8 | Character read at `fetch_addr` |
| fetch_addr | output | ADDR_W | Instruction address register |
| ins_valid | output | 1 | Legal instruction ready to execute |
| ins_ready | input | 1 | Executor takes the instruction |
| ins_bad | output | 1 | Illegal instruction length |
| op_code | output | 7 | Op code without word mark |
| a_addr | output | 21 | A-address, hundreds/tens/units |
| b_addr | output | 21 | B-address, hundreds/tens/units |
| a_char | output | 8 | A character register |
| b_char | output | 8 | B character register |
| d_char | output | 7 | d-modifier |
| d_present | output | 1 | Instruction carries a d-modifier |
| ins_len | output | 4 | Instruction length in characters |

## Verification
The result of a fetch is due one cycle after the terminating character is accepted. The monitor counts the cycles in which `chr_valid` and `chr_ready` are both high and requires that count to equal the characters from the op code through the terminator, whatever the stall pattern, at the first cycle in which the result flag is seen. Register fields are compared in that same cycle against a model built from the requirements, which is carried from one instruction to the next so that chaining and kept B digits are checked. A stall is held for three cycles to confirm that `fetch_addr` stays put. The hold on `ins_valid` is checked two cycles into a withheld `ins_ready`, and idle is checked one cycle after `ins_ready`.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  localparam int CHAR_W  = 8;
  localparam int DATA_W  = 7;
  localparam int WM_BIT  = 7;
  localparam logic [DATA_W-1:0] BLANK = 7'h40;
  localparam logic [5:0] OP_KEEP_MV = 6'h24;
  localparam logic [5:0] OP_KEEP_LD = 6'h23;
  localparam logic [5:0] OP_KEEP_SB = 6'h38;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DONE} fetch_st_t;

  function automatic logic keeps_b(input logic [DATA_W-1:0] op);
    return (op[5:0] == OP_KEEP_MV) || (op[5:0] == OP_KEEP_LD) ||
           (op[5:0] == OP_KEEP_SB);
  endfunction
endpackage

// File: rtl/ifs_seq_ctrl.sv
module ifs_seq_ctrl
  import ifs_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              chr_valid,
  input  logic              chr_wm,
  input  logic              ins_ready,
  input  logic              len_bad,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              chr_ready,
  output logic              acc_op,
  output logic              acc_body,
  output logic              acc_end,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              ins_valid,
  output logic              ins_bad
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  fetch_st_t         st_q;
  logic [ADDR_W-1:0] iar_q;
  logic              taking;

  assign chr_ready  = (st_q == ST_FETCH);
  assign taking     = chr_ready && chr_valid;
  assign acc_op     = taking && (cnt_q == '0);
  assign acc_body   = taking && (cnt_q != '0) && !chr_wm;
  assign acc_end    = taking && (cnt_q != '0) && chr_wm;
  assign ins_valid  = (st_q == ST_DONE) && !len_bad;
  assign ins_bad    = (st_q == ST_DONE) && len_bad;
  assign fetch_addr = iar_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      iar_q <= '0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            iar_q <= start_addr;
            cnt_q <= '0;
            st_q  <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (acc_op || acc_body) begin
            iar_q <= iar_q + 1'b1;
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
          end else if (acc_end) begin
            st_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (ins_valid && ins_ready) begin
            st_q <= ST_IDLE;
          end else if (ins_bad && start) begin
            iar_q <= start_addr;
            cnt_q <= '0;
            st_q  <= ST_FETCH;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_op || acc_body) |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));
  a_r2_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_ready && !chr_valid) |=> $stable(fetch_addr));
  a_r6_end_point: assert property (@(posedge clk) disable iff (!rst_n)
    acc_end |=> (ins_valid || ins_bad) && $stable(fetch_addr));
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready) |=> ins_valid && $stable(cnt_q));
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready) |=> !chr_ready && !ins_valid && !ins_bad);
endmodule

// File: rtl/ifs_len_check.sv
module ifs_len_check #(
  parameter int CNT_W   = 4,
  parameter int DIGITS  = 3,
  parameter int MAX_LEN = 8
) (
  input  logic [CNT_W-1:0] len,
  output logic             len_bad,
  output logic             has_d
);
  localparam int BAD_A = DIGITS;
  localparam int BAD_B = 2 * DIGITS;
  localparam int D_A   = 2;
  localparam int D_B   = DIGITS + 2;
  localparam int D_C   = MAX_LEN;

  always_comb begin
    len_bad = (len == CNT_W'(BAD_A)) || (len == CNT_W'(BAD_B));
    has_d   = (len == CNT_W'(D_A)) || (len == CNT_W'(D_B)) ||
              (len == CNT_W'(D_C));
  end
endmodule

// File: rtl/ifs_addr_regs.sv
module ifs_addr_regs
  import ifs_pkg::*;
#(
  parameter int DIGITS = 3,
  parameter int CNT_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [CNT_W-1:0]         idx,
  input  logic [DATA_W-1:0]        chr,
  input  logic                     keep_b,
  output logic [DIGITS*DATA_W-1:0] a_addr,
  output logic [DIGITS*DATA_W-1:0] b_addr
);
  localparam int B2_BASE = DIGITS + 1;
  localparam int LOW_W   = (DIGITS - 1) * DATA_W;

  logic [DATA_W-1:0] a_dig [DIGITS];
  logic [DATA_W-1:0] b_dig [DIGITS];

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_dig[d] <= BLANK;
      end else if (wr && idx == CNT_W'(1)) begin
        a_dig[d] <= (d == 0) ? chr : BLANK;
      end else if (wr && idx == CNT_W'(d + 1)) begin
        a_dig[d] <= chr;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b_dig[d] <= BLANK;
      end else if (wr && idx == CNT_W'(1)) begin
        if (d == 0)       b_dig[d] <= chr;
        else if (!keep_b) b_dig[d] <= BLANK;
      end else if (wr && idx == CNT_W'(d + 1)) begin
        b_dig[d] <= chr;
      end else if (wr && idx == CNT_W'(B2_BASE)) begin
        b_dig[d] <= (d == 0) ? chr : BLANK;
      end else if (wr && idx == CNT_W'(B2_BASE + d)) begin
        b_dig[d] <= chr;
      end
    end

    assign a_addr[(DIGITS-d)*DATA_W-1 -: DATA_W] = a_dig[d];
    assign b_addr[(DIGITS-d)*DATA_W-1 -: DATA_W] = b_dig[d];
  end

  a_r5_a_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx > CNT_W'(DIGITS)) |=> $stable(a_addr));
  a_r4_b_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == CNT_W'(1) && !keep_b) |=> b_addr[LOW_W-1:0] == {(DIGITS-1){BLANK}});
  a_r4_b_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == CNT_W'(1) && keep_b) |=> $stable(b_addr[LOW_W-1:0]));
  a_r5_b_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == CNT_W'(B2_BASE)) |=> b_addr[LOW_W-1:0] == {(DIGITS-1){BLANK}});
endmodule

// File: rtl/ifs_fetch.sv
module ifs_fetch
  import ifs_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int CNT_W   = 4,
  parameter int DIGITS  = 3,
  parameter int MAX_LEN = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        start_addr,
  input  logic                     chr_valid,
  output logic                     chr_ready,
  input  logic [CHAR_W-1:0]        chr_data,
  output logic [ADDR_W-1:0]        fetch_addr,
  output logic                     ins_valid,
  input  logic                     ins_ready,
  output logic                     ins_bad,
  output logic [DATA_W-1:0]        op_code,
  output logic [DIGITS*DATA_W-1:0] a_addr,
  output logic [DIGITS*DATA_W-1:0] b_addr,
  output logic [CHAR_W-1:0]        a_char,
  output logic [CHAR_W-1:0]        b_char,
  output logic [DATA_W-1:0]        d_char,
  output logic                     d_present,
  output logic [CNT_W-1:0]         ins_len
);
  localparam int D_SHORT = 1;
  localparam int D_MID   = DIGITS + 1;
  localparam int D_LONG  = MAX_LEN - 1;

  logic             acc_op, acc_body, acc_end;
  logic [CNT_W-1:0] idx;
  logic             len_bad, has_d, body_wr, d_wr;
  logic [DATA_W-1:0] op_q, d_q;
  logic [CHAR_W-1:0] a_chr_q, b_chr_q;

  ifs_seq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .chr_valid(chr_valid), .chr_wm(chr_data[WM_BIT]), .ins_ready(ins_ready),
    .len_bad(len_bad), .fetch_addr(fetch_addr), .chr_ready(chr_ready),
    .acc_op(acc_op), .acc_body(acc_body), .acc_end(acc_end), .cnt_q(idx),
    .ins_valid(ins_valid), .ins_bad(ins_bad)
  );

  ifs_len_check #(.CNT_W(CNT_W), .DIGITS(DIGITS), .MAX_LEN(MAX_LEN)) u_len (
    .len(idx), .len_bad(len_bad), .has_d(has_d)
  );

  assign body_wr = acc_body && (idx < CNT_W'(MAX_LEN));
  assign d_wr    = body_wr && (idx == CNT_W'(D_SHORT) || idx == CNT_W'(D_MID) ||
                               idx == CNT_W'(D_LONG));

  ifs_addr_regs #(.DIGITS(DIGITS), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .wr(body_wr), .idx(idx),
    .chr(chr_data[DATA_W-1:0]), .keep_b(keeps_b(op_q)),
    .a_addr(a_addr), .b_addr(b_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= BLANK;
      d_q     <= BLANK;
      a_chr_q <= {1'b0, BLANK};
      b_chr_q <= {1'b0, BLANK};
    end else begin
      if (acc_op) begin
        op_q    <= chr_data[DATA_W-1:0];
        b_chr_q <= chr_data;
      end
      if (body_wr) begin
        a_chr_q <= chr_data;
        b_chr_q <= chr_data;
      end
      if (d_wr) d_q <= chr_data[DATA_W-1:0];
      if (acc_end) b_chr_q <= chr_data;
    end
  end

  assign op_code   = op_q;
  assign d_char    = d_q;
  assign a_char    = a_chr_q;
  assign b_char    = b_chr_q;
  assign ins_len   = idx;
  assign d_present = (ins_valid || ins_bad) && has_d;

  a_r3_op_load: assert property (@(posedge clk) disable iff (!rst_n)
    acc_op |=> op_code == $past(chr_data[DATA_W-1:0]));
  a_r6_b_only: assert property (@(posedge clk) disable iff (!rst_n)
    acc_end |=> $stable(op_code) && $stable(a_char) && $stable(a_addr) &&
                $stable(b_addr) && b_char == $past(chr_data));
  a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_body && !body_wr) |=> $stable(a_char) && $stable(b_char) && $stable(d_char));
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_valid && ins_bad));
  a_r11_copy: assert property (@(posedge clk) disable iff (!rst_n)
    body_wr |=> a_char == $past(chr_data) && b_char == $past(chr_data));
endmodule

// File: tb/test_ifs_fetch.sv
module test_ifs_fetch;
  typedef struct packed {
    logic [6:0]  op;
    logic [20:0] a;
    logic [20:0] b;
    logic [7:0]  ac;
    logic [7:0]  bc;
    logic [6:0]  d;
    logic        dp;
    logic [3:0]  len;
    logic        bad;
    logic [7:0]  end_addr;
    logic [7:0]  nchars;
  } exp_t;

  logic clk = 0, rst_n = 0, start = 0, chr_valid = 0, ins_ready = 0;
  logic [13:0] start_addr = '0;
  logic [7:0]  chr_data;
  logic chr_ready, ins_valid, ins_bad, d_present;
  logic [13:0] fetch_addr;
  logic [6:0]  op_code, d_char;
  logic [20:0] a_addr, b_addr;
  logic [7:0]  a_char, b_char;
  logic [3:0]  ins_len;

  logic [7:0] mem [256];
  exp_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  logic hold_feed = 0, mon_busy = 0;
  logic [20:0] m_a = {3{7'h40}}, m_b = {3{7'h40}};
  logic [7:0]  m_ac = 8'h40, m_bc = 8'h40;
  logic [6:0]  m_op = 7'h40, m_d = 7'h40;

  assign chr_data = mem[fetch_addr[7:0]];

  ifs_fetch i_ifs_fetch (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .chr_valid(chr_valid), .chr_ready(chr_ready), .chr_data(chr_data),
    .fetch_addr(fetch_addr), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_bad(ins_bad), .op_code(op_code), .a_addr(a_addr), .b_addr(b_addr),
    .a_char(a_char), .b_char(b_char), .d_char(d_char), .d_present(d_present),
    .ins_len(ins_len)
  );

  always #2 clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int adr, input logic wm, input logic [6:0] v);
    mem[adr] = {wm, v};
  endtask

  // Reference model written from the requirements
  task automatic model(input int sa, output exp_t e);
    int k = 1;
    int i = sa + 1;
    logic keep;
    logic [7:0] c;
    m_op = mem[sa][6:0];
    m_bc = mem[sa];
    keep = (m_op[5:0] == 6'h24) || (m_op[5:0] == 6'h23) || (m_op[5:0] == 6'h38);
    while (!mem[i][7]) begin
      c = mem[i];
      k++;
      if (k <= 8) begin
        m_ac = c; m_bc = c;
        case (k)
          2: begin m_a = {c[6:0], 7'h40, 7'h40};
                   m_b = keep ? {c[6:0], m_b[13:0]} : {c[6:0], 7'h40, 7'h40}; end
          3: begin m_a[13:7] = c[6:0]; m_b[13:7] = c[6:0]; end
          4: begin m_a[6:0] = c[6:0]; m_b[6:0] = c[6:0]; end
          5: m_b = {c[6:0], 7'h40, 7'h40};
          6: m_b[13:7] = c[6:0];
          7: m_b[6:0] = c[6:0];
          default: ;
        endcase
        if (k == 2 || k == 5 || k == 8) m_d = c[6:0];
      end
      i++;
    end
    m_bc = mem[i];
    e.op = m_op; e.a = m_a; e.b = m_b; e.ac = m_ac; e.bc = m_bc; e.d = m_d;
    e.dp = (k == 2 || k == 5 || k == 8);
    e.len = (k > 15) ? 4'd15 : 4'(k);
    e.bad = (k == 3 || k == 6);
    e.end_addr = 8'(i);
    e.nchars = 8'(i - sa + 1);
  endtask

  task automatic run_instr(input int sa, input logic stall);
    exp_t e;
    model(sa, e);
    q.push_back(e);
    @(negedge clk);
    hold_feed = stall;
    start = 1; start_addr = 14'(sa);
    @(negedge clk);
    start = 0;
    if (stall) begin
      repeat (3) @(negedge clk);
      check(fetch_addr == 14'(sa) && chr_ready, "R2 stall holds fetch_addr",
            {fetch_addr, 3'b0, chr_ready}, {14'(sa), 4'b0001});
      hold_feed = 0;
    end
    while (q.size() != 0 || mon_busy) @(negedge clk);
  endtask

  // feed pattern
  initial forever begin
    @(negedge clk);
    cyc++;
    chr_valid = !hold_feed && (cyc % 4 != 3);
  end

  // monitor / scoreboard
  initial begin
    int acc = 0;
    logic seen = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if ((ins_valid || ins_bad) && !seen) begin
        seen = 1; mon_busy = 1;
        e = q.pop_front();
        check(acc == int'(e.nchars), "R6 result one cycle after terminator", acc, e.nchars);
        check(ins_bad == e.bad && ins_valid == !e.bad, "R8 valid/bad flag",
              {ins_valid, ins_bad}, {!e.bad, e.bad});
        check(op_code == e.op, "R3 op_code", op_code, e.op);
        check(a_addr == e.a, "R4 R5 R7 a_addr", a_addr, e.a);
        check(b_addr == e.b, "R4 R5 R7 b_addr", b_addr, e.b);
        check(a_char == e.ac, "R11 a_char", a_char, e.ac);
        check(b_char == e.bc, "R6 R11 b_char", b_char, e.bc);
        check(ins_len == e.len, "R9 ins_len", ins_len, e.len);
        check(d_present == e.dp, "R10 d_present", d_present, e.dp);
        if (e.dp) check(d_char == e.d, "R10 d_char", d_char, e.d);
        check(fetch_addr[7:0] == e.end_addr, "R6 fetch_addr at terminator",
              fetch_addr, e.end_addr);
        if (ins_valid) begin
          repeat (2) @(negedge clk);
          check(ins_valid && op_code == e.op && ins_len == e.len,
                "R12 hold without ready", {ins_valid, op_code}, {1'b1, e.op});
          ins_ready = 1;
          @(negedge clk);
          ins_ready = 0;
          check(!ins_valid && !chr_ready, "R12 idle after ready",
                {ins_valid, chr_ready}, 2'b00);
        end
        acc = 0;
        mon_busy = 0;
      end else begin
        if (!ins_valid && !ins_bad) seen = 0;
        if (chr_valid && chr_ready) acc++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h40;
    // len7
    put(10, 1, 7'h31); put(11, 0, 7'h01); put(12, 0, 7'h02); put(13, 0, 7'h43);
    put(14, 0, 7'h04); put(15, 0, 7'h45); put(16, 0, 7'h46);
    // len1 chained
    put(17, 1, 7'h20);
    // len4 move op
    put(18, 1, 7'h64); put(19, 0, 7'h07); put(20, 0, 7'h08); put(21, 0, 7'h49);
    // len5
    put(22, 1, 7'h30); put(23, 0, 7'h01); put(24, 0, 7'h02); put(25, 0, 7'h43);
    put(26, 0, 7'h05);
    // len2 load op keeps B tens/units
    put(27, 1, 7'h23); put(28, 0, 7'h51);
    // len2 plain op
    put(29, 1, 7'h2A); put(30, 0, 7'h52);
    // len3 bad
    put(31, 1, 7'h35); put(32, 0, 7'h01); put(33, 0, 7'h02);
    // len6 bad
    put(34, 1, 7'h36);
    for (int i = 1; i <= 5; i++) put(34 + i, 0, 7'(i));
    // len8
    put(40, 1, 7'h37);
    for (int i = 1; i <= 7; i++) put(40 + i, 0, 7'(8'h10 + i));
    // len10
    put(48, 1, 7'h38);
    for (int i = 1; i <= 9; i++) put(48 + i, 0, 7'(8'h20 + i));
    // len1 then terminator
    put(58, 1, 7'h39); put(59, 1, 7'h40);

    repeat (3) @(negedge clk);
    // R1 reset state, before reset release
    check(!chr_ready && !ins_valid && !ins_bad, "R1 flags low",
          {chr_ready, ins_valid, ins_bad}, 3'b000);
    check(op_code == 7'h40 && d_char == 7'h40, "R1 op/d blank", {op_code, d_char}, 14'h2040);
    check(a_addr == {3{7'h40}} && b_addr == {3{7'h40}}, "R1 addresses blank",
          a_addr, {3{7'h40}});
    check(a_char == 8'h40 && b_char == 8'h40 && ins_len == 0, "R1 char regs",
          {a_char, b_char, ins_len}, 20'h40400);
    rst_n = 1;
    @(negedge clk);

    run_instr(10, 1);   // R2 stall, R4 R5 R11
    run_instr(17, 0);   // R7 chaining
    run_instr(18, 0);   // R4
    run_instr(22, 0);   // R5 R10
    run_instr(27, 0);   // R4 keep B, R10
    run_instr(29, 0);   // R4 blank B
    run_instr(31, 0);   // R8 length 3
    run_instr(34, 0);   // R8 length 6, start from bad state
    run_instr(40, 0);   // R10 length 8
    run_instr(48, 0);   // R9 beyond eighth
    run_instr(58, 0);   // R7 after long
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule